// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Bridge

This block joins a command-driven bus initiator to a register-bank responder over a bus that has no shared timing reference. Every transfer is paced by four signal edges: request up, acknowledge up, request down, acknowledge down. The initiator side takes read and write commands on a valid/ready port. It places the address, the direction and (for writes) the data on the bus, and lets them settle for a programmable number of cycles so the responder can decode them. Only then does it raise the request. The responder checks whether the address lies inside its window. If it does, it either hands the write to its register port or puts the addressed register's contents on the read lines, and then raises acknowledge.

Each side passes the other side's handshake line through a two-flop synchroniser, so the two halves can sit on unrelated clocks. A transfer to an address that no responder claims is never acknowledged. The initiator gives up after a bounded wait, withdraws the request and returns an error response. Exactly one response leaves for every command accepted. The response port is valid/ready: a response stays on the port, unchanged, until the consumer takes it, and no new command is accepted until it has been taken.

Top module: `hs_bus_link`

## Requirements
- R1: `cmd_ready` is high only when no transfer is in flight and no response is pending; a command is accepted on a clock where `cmd_valid` and `cmd_ready` are both high, and each accepted command produces exactly one response.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values; the response is consumed on a clock where both are high.
- R3: The bus address and direction stay constant while the request is high, and the request rises no sooner than `DECODE_CYC` clocks after the command was accepted.
- R4: The request rises only while the acknowledge seen by the initiator is low; the acknowledge rises only after the responder has seen the request high, and falls only after the responder has seen it low.
- R5: A write to an address in the window produces exactly one `reg_wr` pulse with `reg_idx` = address − `SLV_BASE` and `reg_wdata` = command data, and a response with `rsp_err` = 0 and `rsp_rdata` = 0.
- R6: A read from an address in the window returns, in `rsp_rdata`, the value on `reg_rdata` for index address − `SLV_BASE`, with `rsp_err` = 0.
- R7: A command to an address outside the window causes no `reg_wr` pulse and returns `rsp_err` = 1 with `rsp_rdata` = 0, no sooner than `TIMEOUT_CYC` clocks after acceptance; the next command then completes normally.
- R8: The window includes `SLV_BASE` and `SLV_BASE + SLV_WORDS − 1`, and excludes `SLV_BASE − 1` and `SLV_BASE + SLV_WORDS`.
- R9: After reset, `cmd_ready` = 1, `rsp_valid` = 0 and `reg_wr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Initiator-side clock |
| rst_m_n | input | 1 | Initiator-side asynchronous reset, active low |
| clk_s | input | 1 | Responder-side clock |
| rst_s_n | input | 1 | Responder-side asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DATA_W | Read data (0 for writes and errors) |
| rsp_err | output | 1 | 1 = no responder acknowledged in time |
| reg_wr | output | 1 | One-clock write strobe to the register bank |
| reg_idx | output | IDX_W | Register index (address − SLV_BASE) |
| reg_wdata | output | DATA_W | Data for the register write |
| reg_rdata | input | DATA_W | Register bank contents at `reg_idx` |

## Verification
The bench targets the window edges on both sides. A responder with an off-by-one compare would either acknowledge a foreign address, writing a register and returning success, or ignore its own top or bottom word, returning a spurious error after the timeout. It throttles `rsp_ready` so that a design that drops or changes a response before it is taken, or accepts a new command early, is caught. It also sends unclaimed transfers between normal ones, to expose a timeout that fires too soon, never fires, leaves the request high or leaks a write strobe. Read-back after writes to every register catches data captured at the wrong handshake edge, which would show up as stale or zero read data.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_SETTLE,
    M_WAIT_ACK,
    M_WAIT_REL,
    M_RESP
  } m_state_e;

  typedef enum logic {
    S_IDLE,
    S_HOLD
  } s_state_e;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int DECODE_CYC  = 2,
  parameter int TIMEOUT_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  input  logic              ack_sync
);
  localparam int CNT_MAX = (DECODE_CYC > TIMEOUT_CYC) ? DECODE_CYC : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(DECODE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST   = CNT_W'(TIMEOUT_CYC - 1);

  m_state_e          st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              read_q;
  logic              err_q;
  logic              req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= M_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      read_q  <= 1'b0;
      err_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      case (st)
        M_IDLE: if (cmd_valid) begin
          addr_q  <= cmd_addr;
          read_q  <= !cmd_write;
          wdata_q <= cmd_write ? cmd_wdata : '0;
          cnt     <= '0;
          st      <= M_SETTLE;
        end
        M_SETTLE: if (cnt == SETTLE_LAST) begin
          req_q <= 1'b1;
          cnt   <= '0;
          st    <= M_WAIT_ACK;
        end else begin
          cnt <= cnt + 1'b1;
        end
        M_WAIT_ACK: if (ack_sync) begin
          req_q   <= 1'b0;
          rdata_q <= read_q ? bus_rdata : '0;
          err_q   <= 1'b0;
          st      <= M_WAIT_REL;
        end else if (cnt == WAIT_LAST) begin
          req_q   <= 1'b0;
          rdata_q <= '0;
          err_q   <= 1'b1;
          st      <= M_WAIT_REL;
        end else begin
          cnt <= cnt + 1'b1;
        end
        M_WAIT_REL: if (!ack_sync) st <= M_RESP;
        M_RESP:     if (rsp_ready) st <= M_IDLE;
        default:    st <= M_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == M_IDLE);
  assign rsp_valid = (st == M_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
  assign bus_addr  = addr_q;
  assign bus_read  = read_q;
  assign bus_wdata = wdata_q;
  assign bus_req   = req_q;
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SLV_BASE  = 64,
  parameter int SLV_WORDS = 8,
  parameter int IDX_W     = $clog2(SLV_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_read,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              slv_oe,
  input  logic              req_sync,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(SLV_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(SLV_BASE + SLV_WORDS);

  s_state_e          st;
  logic              hit;
  logic [ADDR_W:0]   offs;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wd_q;
  logic              ack_q;
  logic              oe_q;
  logic              wr_q;

  assign hit  = ({1'b0, bus_addr} >= WIN_LO) && ({1'b0, bus_addr} < WIN_HI);
  assign offs = {1'b0, bus_addr} - WIN_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      rd_q  <= '0;
      wd_q  <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      case (st)
        S_IDLE: if (req_sync && hit) begin
          ack_q <= 1'b1;
          st    <= S_HOLD;
          if (bus_read) begin
            rd_q <= reg_rdata;
            oe_q <= 1'b1;
          end else begin
            wd_q <= bus_wdata;
            wr_q <= 1'b1;
          end
        end
        S_HOLD: if (!req_sync) begin
          ack_q <= 1'b0;
          oe_q  <= 1'b0;
          rd_q  <= '0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_rdata = oe_q ? rd_q : '0;
  assign bus_ack   = ack_q;
  assign slv_oe    = oe_q;
  assign reg_wr    = wr_q;
  assign reg_idx   = offs[IDX_W-1:0];
  assign reg_wdata = wd_q;
endmodule

// File: rtl/hs_bus_link.sv
module hs_bus_link #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int DECODE_CYC  = 2,
  parameter int TIMEOUT_CYC = 32,
  parameter int SLV_BASE    = 64,
  parameter int SLV_WORDS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(SLV_WORDS)
) (
  input  logic              clk_m,
  input  logic              rst_m_n,
  input  logic              clk_s,
  input  logic              rst_s_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_read;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_req;
  logic              bus_ack;
  logic              slv_oe;
  logic              req_at_s;
  logic              ack_at_m;

  hs_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DECODE_CYC(DECODE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_mst (
    .clk(clk_m), .rst_n(rst_m_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .ack_sync(ack_at_m)
  );

  hs_sync2 #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_s), .rst_n(rst_s_n), .d(bus_req), .q(req_at_s)
  );

  hs_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_m), .rst_n(rst_m_n), .d(bus_ack), .q(ack_at_m)
  );

  hs_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SLV_BASE(SLV_BASE), .SLV_WORDS(SLV_WORDS), .IDX_W(IDX_W)
  ) u_slv (
    .clk(clk_s), .rst_n(rst_s_n),
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .slv_oe(slv_oe),
    .req_sync(req_at_s),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/hs_bus_link_chk.sv
module hs_bus_link_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int DECODE_CYC = 2
) (
  input logic              clk_m,
  input logic              rst_m_n,
  input logic              clk_s,
  input logic              rst_s_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_read,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              req_at_s,
  input logic              ack_at_m,
  input logic              reg_wr,
  input logic              slv_oe
);
  logic [15:0] settle_cnt;

  always_ff @(posedge clk_m or negedge rst_m_n) begin
    if (!rst_m_n)                     settle_cnt <= '0;
    else if (cmd_valid && cmd_ready)  settle_cnt <= '0;
    else if (settle_cnt != 16'hFFFF)  settle_cnt <= settle_cnt + 16'd1;
  end

  // R1
  busy_no_accept_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    cmd_ready |-> (!bus_req && !rsp_valid));

  // R2
  rsp_hold_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R3
  addr_hold_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    bus_req |-> ($stable(bus_addr) && $stable(bus_read)));

  // R3
  settle_gap_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    $rose(bus_req) |-> (settle_cnt >= 16'(DECODE_CYC)));

  // R4
  req_rise_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    $rose(bus_req) |-> !$past(ack_at_m));

  // R4
  ack_rise_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $rose(bus_ack) |-> $past(req_at_s));

  // R4
  ack_fall_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $fell(bus_ack) |-> !$past(req_at_s));

  // R5
  wr_strobe_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    reg_wr |-> (bus_ack && !bus_read));

  // R6
  drive_dir_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    slv_oe |-> (bus_read && bus_ack));
endmodule

bind hs_bus_link hs_bus_link_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE_CYC)
) u_chk (
  .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .bus_addr(bus_addr), .bus_read(bus_read),
  .bus_req(bus_req), .bus_ack(bus_ack),
  .req_at_s(req_at_s), .ack_at_m(ack_at_m),
  .reg_wr(reg_wr), .slv_oe(slv_oe)
);

// File: tb/sim_hs_bus_link.sv
module sim_hs_bus_link;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int DECODE     = 2;
  localparam int TIMEOUT    = 32;
  localparam int BASE       = 64;
  localparam int WORDS      = 8;
  localparam int IDX_W      = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic              cmd_write = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_err;
  logic              reg_wr;
  logic [IDX_W-1:0]  reg_idx;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_bus_link #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE),
    .TIMEOUT_CYC(TIMEOUT), .SLV_BASE(BASE), .SLV_WORDS(WORDS)
  ) u0 (
    .clk_m(clk), .rst_m_n(rst_n), .clk_s(clk), .rst_s_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // Register bank seen through the responder's register port
  logic [DATA_W-1:0] bank [WORDS];
  initial for (int i = 0; i < WORDS; i++) bank[i] = '0;
  always @(posedge clk) if (reg_wr) bank[reg_idx] <= reg_wdata;
  assign reg_rdata = bank[reg_idx];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit stall = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rsp_ready = stall ? (cyc % 3 == 0) : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model
  logic [DATA_W-1:0] shadow [WORDS];
  initial for (int i = 0; i < WORDS; i++) shadow[i] = '0;
  int exp_data[$];
  int exp_err[$];
  int exp_acc[$];
  int wq_idx[$];
  int wq_dat[$];
  bit prev_hold = 1'b0;
  int prev_data = 0;
  int prev_err = 0;
  bit prev_valid = 1'b0;

  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (exp_data.size() > 0 && cmd_ready)
        check(1'b0, "R1 ready while busy", 1, 0);
      if (cmd_valid && cmd_ready) begin
        int a;
        bit inwin;
        a = int'(cmd_addr);
        inwin = (a >= BASE) && (a < BASE + WORDS);
        exp_acc.push_back(cyc);
        exp_err.push_back(inwin ? 0 : 1);
        if (cmd_write) begin
          exp_data.push_back(0);
          if (inwin) begin
            shadow[a - BASE] = cmd_wdata;
            wq_idx.push_back(a - BASE);
            wq_dat.push_back(int'(cmd_wdata));
          end
        end else begin
          exp_data.push_back(inwin ? int'(shadow[a - BASE]) : 0);
        end
      end
      if (rsp_valid) begin
        if (exp_data.size() == 0) begin
          check(1'b0, "R1 response without command", 1, 0);
        end else begin
          if (prev_hold) begin
            check(int'(rsp_rdata) == prev_data, "R2 rdata held", int'(rsp_rdata), prev_data);
            check(int'(rsp_err) == prev_err, "R2 err held", int'(rsp_err), prev_err);
          end
          if (!prev_valid) begin
            int lat;
            lat = cyc - exp_acc[0] - 1;
            if (exp_err[0] != 0)
              check(lat >= TIMEOUT, "R7 timeout latency", lat, TIMEOUT);
            else
              check(lat >= DECODE, "R3 settle latency", lat, DECODE);
          end
          if (rsp_ready) begin
            // R6 and R4: read data is only right if taken at the request drop
            check(int'(rsp_rdata) == exp_data[0], "R5/R6/R7 rsp_rdata", int'(rsp_rdata), exp_data[0]);
            check(int'(rsp_err) == exp_err[0], "R7/R8 rsp_err", int'(rsp_err), exp_err[0]);
            void'(exp_data.pop_front());
            void'(exp_err.pop_front());
            void'(exp_acc.pop_front());
          end
        end
      end else if (prev_hold) begin
        check(1'b0, "R2 response withdrawn", 0, 1);
      end
      if (reg_wr) begin
        if (wq_idx.size() == 0) begin
          check(1'b0, "R7 stray reg_wr", 1, 0);
        end else begin
          check(int'(reg_idx) == wq_idx[0], "R5 reg_idx", int'(reg_idx), wq_idx[0]);
          check(int'(reg_wdata) == wq_dat[0], "R5 reg_wdata", int'(reg_wdata), wq_dat[0]);
          void'(wq_idx.pop_front());
          void'(wq_dat.pop_front());
        end
      end
      prev_hold  = rsp_valid && !rsp_ready;
      prev_valid = rsp_valid;
      prev_data  = int'(rsp_rdata);
      prev_err   = int'(rsp_err);
    end
  end

  task automatic issue(input bit wr, input int addr, input int data);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_addr  = ADDR_W'(addr);
    cmd_wdata = DATA_W'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_data.size() != 0 || !cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(cmd_ready == 1'b1, "R9 cmd_ready in reset", int'(cmd_ready), 1);
    check(rsp_valid == 1'b0, "R9 rsp_valid in reset", int'(rsp_valid), 0);
    check(reg_wr == 1'b0, "R9 reg_wr in reset", int'(reg_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    check(cmd_ready == 1'b1, "R9 cmd_ready after reset", int'(cmd_ready), 1);

    // R5: fill every register
    for (int i = 0; i < WORDS; i++) issue(1'b1, BASE + i, 16'hA500 + i * 16'h0111);
    // R6: read them all back
    for (int i = 0; i < WORDS; i++) issue(1'b0, BASE + i, 0);
    drain();

    // R8: window edges, in and out
    issue(1'b1, BASE, 16'h1234);
    issue(1'b1, BASE + WORDS - 1, 16'hBEEF);
    issue(1'b0, BASE - 1, 0);
    issue(1'b0, BASE + WORDS, 0);
    issue(1'b0, BASE, 0);
    issue(1'b0, BASE + WORDS - 1, 0);
    // R7: unclaimed writes must not reach the bank
    issue(1'b1, BASE - 1, 16'hDEAD);
    issue(1'b1, BASE + WORDS, 16'hDEAD);
    issue(1'b1, 0, 16'hDEAD);
    issue(1'b0, BASE, 0);
    issue(1'b0, BASE + WORDS - 1, 0);
    drain();

    // R2: throttled consumer
    stall = 1'b1;
    issue(1'b1, BASE + 3, 16'h5A5A);
    issue(1'b0, BASE + 3, 0);
    issue(1'b0, 255, 0);
    issue(1'b1, BASE + 5, 16'h0F0F);
    issue(1'b0, BASE + 5, 0);
    for (int i = 0; i < WORDS; i++) issue(1'b0, BASE + i, 0);
    drain();
    stall = 1'b0;

    check(exp_data.size() == 0, "R1 responses outstanding", exp_data.size(), 0);
    check(wq_idx.size() == 0, "R5 writes outstanding", wq_idx.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule